// File: doc/BRIEF.md
# Terminal Line Editor With History

This block sits behind a character link from a terminal and turns a stream of key codes into an editable command line. A printable byte goes in at the cursor position; control codes and three-byte arrow escapes move the cursor, jump to either end of the line, erase on either side of the cursor, or recall earlier lines. Every key is acted on in the clock cycle it arrives. All outputs are registered and change on the next edge, so the block runs at full character rate with no stall.

Pressing enter finishes the line. The block pulses a done flag with the line length and clears the edit buffer. A non-empty line is also written into a small ring of past lines. The most recent entry of that ring stays readable through an index port, and a consumer uses that port to collect the finished text. Up and down recall move through the ring and copy the chosen entry into the edit buffer, with the cursor placed at its end. Inserts, effective backspaces and enter each produce one echo byte, which the link sends back to the terminal.

Top module: `lned_top`

## Requirements
- R1: A printable byte (0x20 to 0x7E) is inserted at the cursor, and the characters from the cursor onward move one place right. The cursor and the length each grow by one, and the byte is echoed.
- R2: When the length equals MAX_LEN, a printable byte changes nothing and produces no echo.
- R3: Ctrl-B (0x02) or ESC '[' 'D' moves the cursor one place left and stops at 0. Ctrl-F (0x06) or ESC '[' 'C' moves it one place right and stops at the line length. The cursor never exceeds the length.
- R4: Ctrl-A (0x01) puts the cursor at 0, and Ctrl-E (0x05) puts it at the line length.
- R5: Backspace (0x08, or 0x7F when RUBOUT_IS_BS is 1) with the cursor above 0 removes the character left of the cursor, moves the cursor left by one and echoes 0x08. With the cursor at 0 it has no effect and no echo.
- R6: Ctrl-D (0x04) with the cursor below the length removes the character under the cursor, closes the gap and leaves the cursor in place. At the line end it has no effect.
- R7: ESC (0x1B) opens an escape. If '[' follows, a third byte of 'A', 'B', 'C' or 'D' acts as up, down, right or left. Any other second or third byte ends the escape, and none of these bytes has any other effect.
- R8: Enter (0x0D) raises done_valid for one cycle with done_len equal to the length before the key, empties the line, sets the cursor to 0 and echoes 0x0D.
- R9: A finished line that is not empty is stored as the newest of HIST_DEPTH history entries, and it replaces the oldest entry when the ring is full. Its character k is then read on done_char while done_idx is k.
- R10: Ctrl-P (0x10) or up recall loads the next older entry and puts the cursor at its end. It stops at the oldest stored entry and does nothing while the history is empty.
- R11: Ctrl-N (0x0E) or down recall loads the next newer entry. It stops at the newest entry and does nothing outside recall. Enter ends recall, so the next up recall loads the newest entry.
- R12: After reset the line is empty, the cursor is 0 and no pulse is raised. Outputs change only on the edge after an accepted byte, and echo_valid is a single-cycle pulse. Unlisted control codes have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | A key byte is present this cycle |
| rx_char | input | 8 | Key byte from the terminal |
| echo_valid | output | 1 | Echo byte present (one cycle) |
| echo_char | output | 8 | Byte to send back to the terminal |
| cursor | output | LW | Cursor position, 0 to line_len |
| line_len | output | LW | Characters in the edit line |
| done_valid | output | 1 | Line finished this cycle |
| done_len | output | LW | Length of the finished line |
| done_idx | input | LW | Character index into the newest history entry |
| done_char | output | 8 | Character of the newest history entry at done_idx |

LW is clog2(MAX_LEN+1).

## Verification
The hardest state to reach is the edge of history recall. The ring must be full and already wrapped, the recall position must sit at the oldest or the newest entry, and a recalled line may have been edited before the next key. The stimulus first commits more lines than the ring holds. It then sends more up keys than there are entries and more down keys than needed, mixing control codes and arrow escapes. It also edits a recalled line, commits it, and follows with an empty enter, so both the overwrite order and the reset of the recall position show up in later loads.

// File: rtl/lned_pkg.sv
package lned_pkg;

   typedef enum logic [3:0] {
      KA_NONE,
      KA_INS,
      KA_LEFT,
      KA_RIGHT,
      KA_HOME,
      KA_END,
      KA_BKSP,
      KA_DEL,
      KA_PREV,
      KA_NEXT,
      KA_ENTER,
      KA_LOAD
   } key_act_e;

   typedef enum logic [1:0] {
      ES_IDLE,
      ES_ESC,
      ES_CSI
   } esc_st_e;

   localparam logic [7:0] KC_HOME  = 8'h01;
   localparam logic [7:0] KC_LEFT  = 8'h02;
   localparam logic [7:0] KC_DEL   = 8'h04;
   localparam logic [7:0] KC_END   = 8'h05;
   localparam logic [7:0] KC_RIGHT = 8'h06;
   localparam logic [7:0] KC_BS    = 8'h08;
   localparam logic [7:0] KC_CR    = 8'h0D;
   localparam logic [7:0] KC_NEXT  = 8'h0E;
   localparam logic [7:0] KC_PREV  = 8'h10;
   localparam logic [7:0] KC_ESC   = 8'h1B;
   localparam logic [7:0] KC_BRKT  = 8'h5B;
   localparam logic [7:0] KC_RUB   = 8'h7F;

endpackage

// File: rtl/lned_keydec.sv
module lned_keydec import lned_pkg::*; #(
   parameter bit RUBOUT_IS_BS = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       in_valid,
   input  logic [7:0] in_char,
   output key_act_e   act
);

   esc_st_e  st_q, st_d;
   key_act_e rub_act;
   logic     printable;

   generate
      if (RUBOUT_IS_BS) begin : g_rub_bs
         assign rub_act = KA_BKSP;
      end else begin : g_rub_off
         assign rub_act = KA_NONE;
      end
   endgenerate

   assign printable = (in_char >= 8'h20) && (in_char <= 8'h7E);

   always_comb begin
      act  = KA_NONE;
      st_d = st_q;
      if (in_valid) begin
         case (st_q)
            ES_IDLE: begin
               if (in_char == KC_ESC) begin
                  st_d = ES_ESC;
               end else if (printable) begin
                  act = KA_INS;
               end else begin
                  case (in_char)
                     KC_HOME:  act = KA_HOME;
                     KC_LEFT:  act = KA_LEFT;
                     KC_DEL:   act = KA_DEL;
                     KC_END:   act = KA_END;
                     KC_RIGHT: act = KA_RIGHT;
                     KC_BS:    act = KA_BKSP;
                     KC_CR:    act = KA_ENTER;
                     KC_NEXT:  act = KA_NEXT;
                     KC_PREV:  act = KA_PREV;
                     KC_RUB:   act = rub_act;
                     default:  act = KA_NONE;
                  endcase
               end
            end
            ES_ESC: begin
               st_d = (in_char == KC_BRKT) ? ES_CSI : ES_IDLE;
            end
            ES_CSI: begin
               st_d = ES_IDLE;
               case (in_char)
                  8'h41:   act = KA_PREV;
                  8'h42:   act = KA_NEXT;
                  8'h43:   act = KA_RIGHT;
                  8'h44:   act = KA_LEFT;
                  default: act = KA_NONE;
               endcase
            end
            default: st_d = ES_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) st_q <= ES_IDLE;
      else        st_q <= st_d;
   end

endmodule

// File: rtl/lned_linebuf.sv
module lned_linebuf import lned_pkg::*; #(
   parameter int MAX_LEN = 255,
   parameter int LW      = $clog2(MAX_LEN + 1)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  key_act_e                    act,
   input  logic [7:0]                  in_char,
   input  logic [MAX_LEN-1:0][7:0]     ld_data,
   input  logic [LW-1:0]               ld_len,
   output logic [MAX_LEN-1:0][7:0]     data,
   output logic [LW-1:0]               len,
   output logic [LW-1:0]               cur,
   output logic                        ins_ok,
   output logic                        bs_ok
);

   localparam logic [LW-1:0] FULL = LW'(MAX_LEN);

   logic [MAX_LEN-1:0][7:0] data_q, data_d;
   logic [LW-1:0]           len_q, len_d, cur_q, cur_d, cur_m1;
   logic                    del_ok;

   assign ins_ok = (len_q != FULL);
   assign bs_ok  = (cur_q != '0);
   assign del_ok = (cur_q != len_q);
   assign cur_m1 = cur_q - LW'(1);

   genvar gi;
   generate
      for (gi = 0; gi < MAX_LEN; gi++) begin : g_slot
         logic [7:0] left_c, right_c;
         if (gi == 0) begin : g_lo
            assign left_c = 8'h00;
         end else begin : g_lo_n
            assign left_c = data_q[gi-1];
         end
         if (gi == MAX_LEN - 1) begin : g_hi
            assign right_c = 8'h00;
         end else begin : g_hi_n
            assign right_c = data_q[gi+1];
         end
         assign data_d[gi] =
            (act == KA_LOAD)                                    ? ld_data[gi] :
            (act == KA_INS  && ins_ok && LW'(gi) == cur_q)      ? in_char     :
            (act == KA_INS  && ins_ok && LW'(gi) >  cur_q)      ? left_c      :
            (act == KA_BKSP && bs_ok  && LW'(gi) >= cur_m1)     ? right_c     :
            (act == KA_DEL  && del_ok && LW'(gi) >= cur_q)      ? right_c     :
                                                                  data_q[gi];
      end
   endgenerate

   always_comb begin
      len_d = len_q;
      cur_d = cur_q;
      case (act)
         KA_INS: if (ins_ok) begin
            len_d = len_q + LW'(1);
            cur_d = cur_q + LW'(1);
         end
         KA_LEFT:  if (bs_ok)  cur_d = cur_m1;
         KA_RIGHT: if (del_ok) cur_d = cur_q + LW'(1);
         KA_HOME:  cur_d = '0;
         KA_END:   cur_d = len_q;
         KA_BKSP: if (bs_ok) begin
            len_d = len_q - LW'(1);
            cur_d = cur_m1;
         end
         KA_DEL: if (del_ok) len_d = len_q - LW'(1);
         KA_LOAD: begin
            len_d = ld_len;
            cur_d = ld_len;
         end
         KA_ENTER: begin
            len_d = '0;
            cur_d = '0;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         data_q <= '0;
         len_q  <= '0;
         cur_q  <= '0;
      end else begin
         data_q <= data_d;
         len_q  <= len_d;
         cur_q  <= cur_d;
      end
   end

   assign data = data_q;
   assign len  = len_q;
   assign cur  = cur_q;

endmodule

// File: rtl/lned_history.sv
module lned_history #(
   parameter int MAX_LEN = 255,
   parameter int DEPTH   = 4,
   parameter int LW      = $clog2(MAX_LEN + 1),
   parameter int AW      = $clog2(DEPTH),
   parameter int CW      = $clog2(DEPTH + 1)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    push,
   input  logic [MAX_LEN-1:0][7:0] push_data,
   input  logic [LW-1:0]           push_len,
   input  logic [AW-1:0]           rd_age,
   output logic [MAX_LEN-1:0][7:0] rd_data,
   output logic [LW-1:0]           rd_len,
   output logic [MAX_LEN-1:0][7:0] new_data,
   output logic [CW-1:0]           count
);

   logic [DEPTH-1:0][MAX_LEN-1:0][7:0] mem_q;
   logic [DEPTH-1:0][LW-1:0]           mlen_q;
   logic [AW-1:0]                      wp_q, rd_slot, new_slot;
   logic [CW-1:0]                      cnt_q;

   assign new_slot = wp_q - AW'(1);
   assign rd_slot  = new_slot - rd_age;
   assign rd_data  = mem_q[rd_slot];
   assign rd_len   = mlen_q[rd_slot];
   assign new_data = mem_q[new_slot];
   assign count    = cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mem_q  <= '0;
         mlen_q <= '0;
         wp_q   <= '0;
         cnt_q  <= '0;
      end else if (push) begin
         mem_q[wp_q]  <= push_data;
         mlen_q[wp_q] <= push_len;
         wp_q         <= wp_q + AW'(1);
         if (cnt_q != CW'(DEPTH)) cnt_q <= cnt_q + CW'(1);
      end
   end

endmodule

// File: rtl/lned_top.sv
module lned_top import lned_pkg::*; #(
   parameter int MAX_LEN      = 255,
   parameter int HIST_DEPTH   = 4,
   parameter bit RUBOUT_IS_BS = 1'b1,
   localparam int LW = $clog2(MAX_LEN + 1),
   localparam int AW = $clog2(HIST_DEPTH),
   localparam int CW = $clog2(HIST_DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rx_valid,
   input  logic [7:0]    rx_char,
   output logic          echo_valid,
   output logic [7:0]    echo_char,
   output logic [LW-1:0] cursor,
   output logic [LW-1:0] line_len,
   output logic          done_valid,
   output logic [LW-1:0] done_len,
   input  logic [LW-1:0] done_idx,
   output logic [7:0]    done_char
);

   generate
      if (MAX_LEN < 2) begin : g_bad_len
         $error("lned_top: MAX_LEN must be at least 2");
      end
      if (HIST_DEPTH < 2 || (HIST_DEPTH & (HIST_DEPTH - 1)) != 0) begin : g_bad_depth
         $error("lned_top: HIST_DEPTH must be a power of two, 2 or more");
      end
   endgenerate

   key_act_e                raw_act, buf_act;
   logic [MAX_LEN-1:0][7:0] line_data, rec_data, newest_data;
   logic [LW-1:0]           rec_len;
   logic [CW-1:0]           hist_cnt, rpos_q;
   logic [AW-1:0]           rec_age;
   logic                    ins_ok, bs_ok, prev_ok, next_ok, push;
   logic                    echo_v_q, done_v_q;
   logic [7:0]              echo_c_q;
   logic [LW-1:0]           done_len_q;

   lned_keydec #(.RUBOUT_IS_BS(RUBOUT_IS_BS)) u_dec (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (rx_valid),
      .in_char  (rx_char),
      .act      (raw_act)
   );

   assign prev_ok = (raw_act == KA_PREV) && (rpos_q < hist_cnt);
   assign next_ok = (raw_act == KA_NEXT) && (rpos_q > CW'(1));
   assign rec_age = (raw_act == KA_PREV) ? AW'(rpos_q) : AW'(rpos_q - CW'(2));

   always_comb begin
      if (prev_ok || next_ok)                            buf_act = KA_LOAD;
      else if (raw_act == KA_PREV || raw_act == KA_NEXT) buf_act = KA_NONE;
      else                                               buf_act = raw_act;
   end

   lned_linebuf #(.MAX_LEN(MAX_LEN), .LW(LW)) u_line (
      .clk     (clk),
      .rst_n   (rst_n),
      .act     (buf_act),
      .in_char (rx_char),
      .ld_data (rec_data),
      .ld_len  (rec_len),
      .data    (line_data),
      .len     (line_len),
      .cur     (cursor),
      .ins_ok  (ins_ok),
      .bs_ok   (bs_ok)
   );

   assign push = (raw_act == KA_ENTER) && (line_len != '0);

   lned_history #(.MAX_LEN(MAX_LEN), .DEPTH(HIST_DEPTH), .LW(LW), .AW(AW), .CW(CW)) u_hist (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (push),
      .push_data (line_data),
      .push_len  (line_len),
      .rd_age    (rec_age),
      .rd_data   (rec_data),
      .rd_len    (rec_len),
      .new_data  (newest_data),
      .count     (hist_cnt)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rpos_q     <= '0;
         echo_v_q   <= 1'b0;
         echo_c_q   <= 8'h00;
         done_v_q   <= 1'b0;
         done_len_q <= '0;
      end else begin
         if (raw_act == KA_ENTER) rpos_q <= '0;
         else if (prev_ok)        rpos_q <= rpos_q + CW'(1);
         else if (next_ok)        rpos_q <= rpos_q - CW'(1);

         echo_v_q <= 1'b0;
         if (raw_act == KA_INS && ins_ok) begin
            echo_v_q <= 1'b1;
            echo_c_q <= rx_char;
         end else if (raw_act == KA_BKSP && bs_ok) begin
            echo_v_q <= 1'b1;
            echo_c_q <= KC_BS;
         end else if (raw_act == KA_ENTER) begin
            echo_v_q <= 1'b1;
            echo_c_q <= KC_CR;
         end

         done_v_q <= (raw_act == KA_ENTER);
         if (raw_act == KA_ENTER) done_len_q <= line_len;
      end
   end

   assign echo_valid = echo_v_q;
   assign echo_char  = echo_c_q;
   assign done_valid = done_v_q;
   assign done_len   = done_len_q;
   assign done_char  = (done_idx < LW'(MAX_LEN)) ? newest_data[done_idx] : 8'h00;

endmodule

// File: rtl/lned_checker.sv
module lned_checker #(
   parameter int MAX_LEN = 255,
   parameter int LW      = $clog2(MAX_LEN + 1)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          rx_valid,
   input logic          echo_valid,
   input logic [7:0]    echo_char,
   input logic [LW-1:0] cursor,
   input logic [LW-1:0] line_len,
   input logic          done_valid,
   input logic [LW-1:0] done_len
);

   AST_CUR_WITHIN_LINE: assert property (@(posedge clk) disable iff (!rst_n)
      cursor <= line_len);                                                    // R3
   AST_LEN_CAPPED: assert property (@(posedge clk) disable iff (!rst_n)
      line_len <= LW'(MAX_LEN));                                              // R2
   AST_DONE_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      done_valid |-> (line_len == '0 && cursor == '0));                       // R8
   AST_DONE_LEN_PREV: assert property (@(posedge clk) disable iff (!rst_n)
      done_valid |-> (done_len == $past(line_len)));                          // R8
   AST_ECHO_NEEDS_KEY: assert property (@(posedge clk) disable iff (!rst_n)
      echo_valid |-> $past(rx_valid));                                        // R12
   AST_QUIET_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(rx_valid) |-> ($stable(line_len) && $stable(cursor)));           // R12
   AST_INSERT_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
      (echo_valid && echo_char >= 8'h20 && echo_char <= 8'h7E)
         |-> (line_len == $past(line_len) + LW'(1)));                         // R1
   AST_BS_STEPS_BACK: assert property (@(posedge clk) disable iff (!rst_n)
      (echo_valid && echo_char == 8'h08) |-> (cursor == $past(cursor) - LW'(1))); // R5

endmodule

bind lned_top lned_checker #(.MAX_LEN(MAX_LEN), .LW(LW)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .rx_valid   (rx_valid),
   .echo_valid (echo_valid),
   .echo_char  (echo_char),
   .cursor     (cursor),
   .line_len   (line_len),
   .done_valid (done_valid),
   .done_len   (done_len)
);

// File: tb/lned_top_test.sv
module lned_top_test;

   localparam int MAXL = 12;
   localparam int HD   = 4;
   localparam int LW   = $clog2(MAXL + 1);

   logic          clk = 1'b0;
   logic          rst_n;
   logic          rx_valid;
   logic [7:0]    rx_char;
   logic          echo_valid;
   logic [7:0]    echo_char;
   logic [LW-1:0] cursor, line_len, done_len, done_idx;
   logic          done_valid;
   logic [7:0]    done_char;

   always #4 clk = ~clk;

   lned_top #(.MAX_LEN(MAXL), .HIST_DEPTH(HD), .RUBOUT_IS_BS(1'b1)) uut (
      .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_char(rx_char),
      .echo_valid(echo_valid), .echo_char(echo_char), .cursor(cursor),
      .line_len(line_len), .done_valid(done_valid), .done_len(done_len),
      .done_idx(done_idx), .done_char(done_char)
   );

   int    errors = 0;
   int    checks = 0;
   string tag = "R12";

   logic [7:0]        mline[$];
   int                mcur = 0;
   logic [8*MAXL-1:0] hdat[$];
   int                hlen[$];
   int                rpos = 0;
   int                esc = 0;
   logic              exp_ev = 1'b0;
   logic [7:0]        exp_ec = 8'h00;
   logic              exp_dv = 1'b0;
   int                exp_dl = 0;

   task automatic chk(string r, int act, int exp, string what);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", r, what, act, exp);
      end
   endtask

   task automatic mload(int idx);
      mline.delete();
      for (int k = 0; k < hlen[idx]; k++) mline.push_back(hdat[idx][8*k +: 8]);
      mcur = hlen[idx];
   endtask

   task automatic model_key(logic [7:0] c);
      int op = 0;
      logic [8*MAXL-1:0] pk;
      exp_ev = 1'b0;
      exp_dv = 1'b0;
      if (esc == 1) begin
         esc = (c == 8'h5B) ? 2 : 0;
         return;
      end
      if (esc == 2) begin
         esc = 0;
         case (c)
            8'h41: op = 8; 8'h42: op = 9; 8'h43: op = 3; 8'h44: op = 2;
            default: op = 0;
         endcase
      end else if (c == 8'h1B) begin
         esc = 1;
         return;
      end else if (c >= 8'h20 && c <= 8'h7E) begin
         op = 1;
      end else begin
         case (c)
            8'h01: op = 4; 8'h02: op = 2; 8'h04: op = 7; 8'h05: op = 5;
            8'h06: op = 3; 8'h08: op = 6; 8'h7F: op = 6; 8'h0D: op = 10;
            8'h0E: op = 9; 8'h10: op = 8;
            default: op = 0;
         endcase
      end
      case (op)
         1: if (mline.size() < MAXL) begin
               mline.insert(mcur, c); mcur++; exp_ev = 1'b1; exp_ec = c;
            end
         2: if (mcur > 0) mcur--;
         3: if (mcur < mline.size()) mcur++;
         4: mcur = 0;
         5: mcur = mline.size();
         6: if (mcur > 0) begin
               mline.delete(mcur - 1); mcur--; exp_ev = 1'b1; exp_ec = 8'h08;
            end
         7: if (mcur < mline.size()) mline.delete(mcur);
         8: if (rpos < hdat.size()) begin
               rpos++; mload(hdat.size() - rpos);
            end
         9: if (rpos > 1) begin
               rpos--; mload(hdat.size() - rpos);
            end
         10: begin
            exp_ev = 1'b1; exp_ec = 8'h0D; exp_dv = 1'b1; exp_dl = mline.size();
            if (mline.size() > 0) begin
               pk = '0;
               for (int k = 0; k < mline.size(); k++) pk[8*k +: 8] = mline[k];
               hdat.push_back(pk);
               hlen.push_back(mline.size());
               if (hdat.size() > HD) begin
                  void'(hdat.pop_front());
                  void'(hlen.pop_front());
               end
            end
            mline.delete(); mcur = 0; rpos = 0;
         end
         default: ;
      endcase
   endtask

   task automatic compare();
      chk(tag, int'(cursor), mcur, "cursor");
      chk(tag, int'(line_len), mline.size(), "line_len");
      chk(tag, int'(echo_valid), int'(exp_ev), "echo_valid");
      if (exp_ev) chk(tag, int'(echo_char), int'(exp_ec), "echo_char");
      chk(tag, int'(done_valid), int'(exp_dv), "done_valid");
      if (exp_dv) chk(tag, int'(done_len), exp_dl, "done_len");
   endtask

   task automatic send(logic [7:0] c);
      rx_valid = 1'b1;
      rx_char  = c;
      model_key(c);
      @(negedge clk);
      rx_valid = 1'b0;
      compare();
   endtask

   task automatic idle();
      exp_ev = 1'b0;
      exp_dv = 1'b0;
      @(negedge clk);
      compare();
   endtask

   task automatic type_str(string s);
      for (int i = 0; i < s.len(); i++) send(s[i]);
   endtask

   task automatic read_back(string r);
      int last = hdat.size() - 1;
      for (int k = 0; k < hlen[last]; k++) begin
         done_idx = LW'(k);
         idle();
         chk(r, int'(done_char), int'(hdat[last][8*k +: 8]), "done_char");
      end
   endtask

   task automatic esc_seq(logic [7:0] c);
      send(8'h1B); send(8'h5B); send(c);
   endtask

   initial begin
      #(8 * 150000);
      errors++;
      checks++;
      $display("FAIL R12 watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      rst_n = 1'b0; rx_valid = 1'b0; rx_char = 8'h00; done_idx = '0;
      repeat (3) @(negedge clk);
      tag = "R12"; compare();
      rst_n = 1'b1;
      idle();
      tag = "R10"; send(8'h10);
      tag = "R11"; send(8'h0E);
      tag = "R12"; send(8'h07); send(8'h00); send(8'h1F); idle();
      tag = "R1"; type_str("abc"); send(8'h02); send(8'h02); send("X");
      tag = "R8"; send(8'h0D);
      read_back("R9");
      tag = "R3"; type_str("hey"); send(8'h06);
      send(8'h02); send(8'h02); send(8'h02); send(8'h02);
      tag = "R4"; send(8'h05); send(8'h01);
      tag = "R5"; send(8'h08); send(8'h05); send(8'h08); send(8'h01); send(8'h06); send(8'h7F);
      tag = "R6"; send(8'h05); send(8'h04); type_str("mnop"); send(8'h01); send(8'h06);
      send(8'h04); send(8'h04);
      tag = "R8"; send(8'h0D); read_back("R6");
      tag = "R7"; type_str("uv"); esc_seq(8'h44); esc_seq(8'h44); esc_seq(8'h43);
      send(8'h1B); send("x"); esc_seq(8'h5A); send(8'h1B); send(8'h1B);
      type_str("q"); send(8'h0D); read_back("R7");
      tag = "R2"; type_str("abcdefghijklm"); send(8'h01); send("z"); send(8'h06); send("y");
      send(8'h0D); read_back("R2");
      tag = "R9"; type_str("l1"); send(8'h0D); type_str("l2"); send(8'h0D);
      type_str("l3"); send(8'h0D); type_str("l4"); send(8'h0D);
      type_str("l5"); send(8'h0D); read_back("R9");
      tag = "R10"; for (int i = 0; i < 6; i++) send(8'h10);
      tag = "R11"; for (int i = 0; i < 6; i++) send(8'h0E);
      tag = "R10"; esc_seq(8'h41); esc_seq(8'h41);
      tag = "R11"; esc_seq(8'h42); type_str("!"); send(8'h0D); read_back("R11");
      send(8'h0D);
      send(8'h10); send(8'h10); send(8'h0E); send(8'h0E);
      tag = "R1"; send(8'h01); send("#"); send(8'h0D); read_back("R1");
      idle(); idle();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule